// File: doc/BRIEF.md
# Privileged Clock and Voltage Setting Register Block

This block holds the frequency-scaling and supply-voltage settings for a chip's clock and power controllers, on behalf of a trusted root-of-trust controller. Every requester reaches it over one simple register bus. Each access carries an address, a write flag, write data and a privilege tag. The block answers with registered read data and a one-cycle error pulse.

The settings sit in a contiguous, inclusive address window. Writes to that window pass only while a lock bit is clear, and only a privileged requester can change the lock bit. Application cores reach the block through a shared interface and are untrusted. Nothing they send can clear the lock or alter a setting. Their writes to the window are refused whatever the lock state. All other addresses behave as ordinary scratch registers that anyone may write. The settings and the lock state are also driven out as plain outputs to the clock and voltage logic.

Top module: `dvfs_guard_regs`

## Requirements
- R1: With default parameters the guarded window covers addresses 4 through 7, both bounds included. Address 0 is the lock register, and the lock is bit 0 of that register (1 = locked). Addresses 3 and 8 lie outside the window.
- R2: After reset the lock reads 1, every window register holds the safe value 0x0008, every ordinary register holds 0, and rsp_err and rsp_rdata are 0.
- R3: Only a write with req_priv=1 to the lock address changes the lock, which takes write-data bit 0. A lock write with req_priv=0 is refused and leaves the lock unchanged.
- R4: A write with req_priv=0 to any window address is refused whatever the lock state.
- R5: While the lock is 1, a privileged write to a window address is refused.
- R6: While the lock is 0, a privileged write to a window address is accepted at the clock edge that samples it.
- R7: A refused write changes no register and raises rsp_err for exactly the one cycle after the request. rsp_err is 0 in every other cycle.
- R8: Writes to ordinary addresses are accepted from any requester whatever the lock state, and never raise rsp_err.
- R9: Reads are allowed for every requester and never raise rsp_err. rsp_rdata shows the addressed value in the cycle after the request and holds it until the next read. A read of the lock address returns the lock in bit 0 and zeros above it.
- R10: settings_o shows the window registers in address order, with the lowest window address in bits [15:0]. lock_o shows the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = access from the trusted controller |
| req_addr | input | ADDR_W (4) | Register address |
| req_wdata | input | DATA_W (16) | Write data |
| rsp_rdata | output | DATA_W (16) | Registered read data |
| rsp_err | output | 1 | Refused-write pulse, one cycle after the request |
| lock_o | output | 1 | Current lock state |
| settings_o | output | WIN_CNT*DATA_W (64) | Window registers, lowest address in the low bits |

## Verification
Every cycle, the assertions check three things. Unprivileged writes to the window or the lock leave settings_o and lock_o unchanged and raise the error pulse. Locked window writes are refused. The lock moves only after a privileged lock write, and the error pulse appears only after a write. Only the bench scenarios can show that accepted writes store the exact data at the exact address and that read data matches the stored values. They also exercise every window address, from both privilege levels and in both lock states, and the boundary addresses next to the window.

// File: rtl/dvfs_guard_pkg.sv
package dvfs_guard_pkg;
    // Class of the register an access targets
    typedef enum logic [1:0] {
        AREA_PLAIN = 2'd0,
        AREA_LOCK  = 2'd1,
        AREA_WIN   = 2'd2
    } area_e;
endpackage

// File: rtl/dvfs_guard_decode.sv
module dvfs_guard_decode
    import dvfs_guard_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int LOCK_ADDR = 0,
    parameter int WIN_LO    = 4,
    parameter int WIN_HI    = 7
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              lock_q,
    output area_e             area,
    output logic              wr_ok,
    output logic              wr_deny
);
    localparam logic [ADDR_W-1:0] LO_A   = ADDR_W'(WIN_LO);
    localparam logic [ADDR_W-1:0] HI_A   = ADDR_W'(WIN_HI);
    localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_ADDR);

    logic attempt;
    logic permit;

    always_comb begin
        if (req_addr == LOCK_A)
            area = AREA_LOCK;
        else if (req_addr >= LO_A && req_addr <= HI_A)
            area = AREA_WIN;
        else
            area = AREA_PLAIN;

        unique case (area)
            AREA_LOCK: permit = req_priv;
            AREA_WIN:  permit = req_priv && !lock_q;
            default:   permit = 1'b1;
        endcase

        attempt = req_valid && req_write;
        wr_ok   = attempt && permit;
        wr_deny = attempt && !permit;
    end
endmodule

// File: rtl/dvfs_guard_store.sv
module dvfs_guard_store #(
    parameter int                ADDR_W   = 4,
    parameter int                DATA_W   = 16,
    parameter int                WIN_LO   = 4,
    parameter int                WIN_HI   = 7,
    parameter logic [DATA_W-1:0] SAFE_VAL = 16'h0008,
    localparam int               NREG     = 1 << ADDR_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_ok,
    input  logic                         wr_lock,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    output logic                         lock_q,
    output logic [NREG-1:0][DATA_W-1:0]  regs_q
);
    typedef struct packed {
        logic                        lock;
        logic [NREG-1:0][DATA_W-1:0] regs;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s.lock = 1'b1;
        for (int i = 0; i < NREG; i++)
            s.regs[i] = (i >= WIN_LO && i <= WIN_HI) ? SAFE_VAL : '0;
        return s;
    endfunction

    localparam state_t RST_ST = reset_state();

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            if (wr_lock)
                st_d.lock = wr_data[0];
            else
                st_d.regs[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= RST_ST;
        else
            st_q <= st_d;
    end

    assign lock_q = st_q.lock;
    assign regs_q = st_q.regs;
endmodule

// File: rtl/dvfs_guard_resp.sv
module dvfs_guard_resp #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] rd_val,
    input  logic              wr_deny,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } resp_t;

    resp_t rs_d, rs_q;

    always_comb begin
        rs_d     = rs_q;
        rs_d.err = wr_deny;
        if (rd_en)
            rs_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rs_q <= '0;
        else
            rs_q <= rs_d;
    end

    assign rsp_rdata = rs_q.rdata;
    assign rsp_err   = rs_q.err;
endmodule

// File: rtl/dvfs_guard_regs.sv
module dvfs_guard_regs
    import dvfs_guard_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter int                DATA_W    = 16,
    parameter int                LOCK_ADDR = 0,
    parameter int                WIN_LO    = 4,
    parameter int                WIN_HI    = 7,
    parameter logic [DATA_W-1:0] SAFE_VAL  = 16'h0008,
    localparam int               WIN_CNT   = WIN_HI - WIN_LO + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic                      req_priv,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic [DATA_W-1:0]         rsp_rdata,
    output logic                      rsp_err,
    output logic                      lock_o,
    output logic [WIN_CNT*DATA_W-1:0] settings_o
);
    localparam int NREG = 1 << ADDR_W;

    area_e                       area;
    logic                        wr_ok;
    logic                        wr_deny;
    logic                        lock_q;
    logic [NREG-1:0][DATA_W-1:0] regs_q;
    logic [DATA_W-1:0]           rd_val;
    logic                        rd_en;

    dvfs_guard_decode #(
        .ADDR_W(ADDR_W), .LOCK_ADDR(LOCK_ADDR), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
    ) u_decode (
        .req_valid(req_valid), .req_write(req_write), .req_priv(req_priv),
        .req_addr(req_addr), .lock_q(lock_q), .area(area),
        .wr_ok(wr_ok), .wr_deny(wr_deny)
    );

    dvfs_guard_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
        .SAFE_VAL(SAFE_VAL)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_lock(area == AREA_LOCK),
        .wr_addr(req_addr), .wr_data(req_wdata), .lock_q(lock_q), .regs_q(regs_q)
    );

    always_comb begin
        rd_en = req_valid && !req_write;
        if (area == AREA_LOCK)
            rd_val = {{(DATA_W-1){1'b0}}, lock_q};
        else
            rd_val = regs_q[req_addr];
    end

    dvfs_guard_resp #(
        .DATA_W(DATA_W)
    ) u_resp (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_val(rd_val),
        .wr_deny(wr_deny), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    for (genvar g = 0; g < WIN_CNT; g++) begin : g_win_out
        assign settings_o[g*DATA_W +: DATA_W] = regs_q[WIN_LO + g];
    end

    assign lock_o = lock_q;
endmodule

// File: rtl/dvfs_guard_chk.sv
module dvfs_guard_chk #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 16,
    parameter int LOCK_ADDR = 0,
    parameter int WIN_LO    = 4,
    parameter int WIN_HI    = 7,
    localparam int WIN_CNT  = WIN_HI - WIN_LO + 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic                      req_write,
    input logic                      req_priv,
    input logic [ADDR_W-1:0]         req_addr,
    input logic                      rsp_err,
    input logic                      lock_o,
    input logic [WIN_CNT*DATA_W-1:0] settings_o
);
    localparam logic [ADDR_W-1:0] LO_A   = ADDR_W'(WIN_LO);
    localparam logic [ADDR_W-1:0] HI_A   = ADDR_W'(WIN_HI);
    localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_ADDR);

    logic wr, in_win, at_lock;
    assign wr      = req_valid && req_write;
    assign in_win  = (req_addr >= LO_A) && (req_addr <= HI_A);
    assign at_lock = (req_addr == LOCK_A);

    // R4
    win_unpriv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !req_priv && in_win |=> $stable(settings_o) && rsp_err);

    // R3
    lock_unpriv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !req_priv && at_lock |=> $stable(lock_o) && rsp_err);

    // R3
    lock_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && req_priv && at_lock) |=> $stable(lock_o));

    // R5
    win_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && lock_o && in_win |=> $stable(settings_o) && rsp_err);

    // R8
    plain_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !in_win && !at_lock |=> !rsp_err);

    // R9
    read_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> !rsp_err);

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> !rsp_err);
endmodule

bind dvfs_guard_regs dvfs_guard_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_ADDR(LOCK_ADDR),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_priv(req_priv), .req_addr(req_addr), .rsp_err(rsp_err),
    .lock_o(lock_o), .settings_o(settings_o)
);

// File: tb/tb_dvfs_guard_regs.sv
module tb_dvfs_guard_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_priv = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rsp_rdata;
    logic        rsp_err;
    logic        lock_o;
    logic [63:0] settings_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_regs [16];
    logic        m_lock;
    logic [15:0] m_rdata;

    always #10 clk = ~clk;

    dvfs_guard_regs dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_priv(req_priv), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .lock_o(lock_o),
        .settings_o(settings_o)
    );

    function automatic bit is_win(logic [3:0] a);
        return a >= 4'd4 && a <= 4'd7;
    endfunction

    function automatic bit allowed(logic [3:0] a, bit p);
        if (a == 4'd0) return p;
        if (is_win(a)) return p && !m_lock;
        return 1'b1;
    endfunction

    function automatic logic [63:0] exp_settings();
        logic [63:0] r;
        for (int i = 0; i < 4; i++) r[i*16 +: 16] = m_regs[4+i];
        return r;
    endfunction

    function automatic string tag_of(bit wr, logic [3:0] a, bit p);
        if (!wr) return "R9";
        if (a == 4'd0) return "R3";
        if (is_win(a)) begin
            if (!p) return "R4";
            return m_lock ? "R5" : "R6";
        end
        return "R8";
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(bit wr, logic [3:0] a, logic [15:0] d, bit p);
        string tag;
        bit    exp_err;
        tag = tag_of(wr, a, p);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_priv = p;
        exp_err = wr && !allowed(a, p);
        if (!wr) m_rdata = (a == 4'd0) ? {15'd0, m_lock} : m_regs[a];
        else if (!exp_err) begin
            if (a == 4'd0) m_lock = d[0];
            else m_regs[a] = d;
        end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk(rsp_err == exp_err, tag, 64'(rsp_err), 64'(exp_err));
        if (!wr) chk(rsp_rdata == m_rdata, tag, 64'(rsp_rdata), 64'(m_rdata));
        chk(lock_o == m_lock, tag, 64'(lock_o), 64'(m_lock));
        chk(settings_o == exp_settings(), "R10", settings_o, exp_settings());
    endtask

    task automatic idle_err_check();
        @(negedge clk);
        // R7: error lasts a single cycle
        chk(rsp_err == 1'b0, "R7", 64'(rsp_err), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) m_regs[i] = (i >= 4 && i <= 7) ? 16'h0008 : 16'h0000;
        m_lock = 1'b1;
        m_rdata = '0;
        repeat (3) @(negedge clk);
        // R2: reset state
        chk(lock_o == 1'b1, "R2", 64'(lock_o), 64'd1);
        chk(settings_o == {4{16'h0008}}, "R2", settings_o, {4{16'h0008}});
        chk(rsp_err == 1'b0, "R2", 64'(rsp_err), 64'd0);
        chk(rsp_rdata == 16'd0, "R2", 64'(rsp_rdata), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        access(0, 4'd1, 16'h0, 0);              // R2 ordinary reg reads 0
        access(0, 4'd0, 16'h0, 0);              // R9 lock readback
        // R4 every window address, locked
        for (int a = 4; a <= 7; a++) begin
            access(1, 4'(a), 16'hDEAD, 0);
            idle_err_check();
        end
        // R5 privileged but locked
        for (int a = 4; a <= 7; a++) access(1, 4'(a), 16'hBEEF, 1);
        // R3 unprivileged attempt to clear lock
        access(1, 4'd0, 16'h0000, 0);
        idle_err_check();
        // R1 boundary addresses outside window, locked, unprivileged
        access(1, 4'd3, 16'h1233, 0);
        access(1, 4'd8, 16'h1288, 0);
        access(0, 4'd3, 16'h0, 0);
        // R3 privileged clear of lock
        access(1, 4'd0, 16'hFFFE, 1);
        // R4 every window address, unlocked
        for (int a = 4; a <= 7; a++) access(1, 4'(a), 16'hCAFE, 0);
        // R6 privileged writes to window while unlocked
        for (int a = 4; a <= 7; a++) access(1, 4'(a), 16'(16'h0100 + a), 1);
        for (int a = 4; a <= 7; a++) access(0, 4'(a), 16'h0, 0);
        // R3 unprivileged cannot set it either; privileged relocks
        access(1, 4'd0, 16'h0001, 0);
        access(1, 4'd0, 16'h0001, 1);
        access(0, 4'd0, 16'h0, 1);
        // random mix
        for (int n = 0; n < 600; n++) begin
            access(1'($urandom % 2), 4'($urandom % 16), 16'($urandom), 1'($urandom % 2));
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule